// File: doc/BRIEF.md
# Double-Edge Serial ADC Lane Deserializer

This block turns the one-bit serial outputs of an eight-lane ADC into parallel sample words. A bit clock comes with the lanes. Every lane presents one bit before each rising edge and one before each falling edge of that clock. A frame clock marks where each sample starts. Inside each lane, two shift chains run side by side: one is clocked on the rising edge and one on the falling edge. When a new frame begins, the two chains are interleaved into one right-justified word. The word is 8, 10, 12 or 14 bits wide, set by a two-bit resolution code.

The finished lane words cross into the frame-clock domain. There they are split into two groups of four lanes. Each group has its own two-bit lane select and produces one registered word, a valid flag and a forwarded clock. The forwarded clock is the inverted frame clock, so its rising edge falls mid-frame, while the data is stable. Both groups present a word at the same time. The resolution code is quasi-static and is changed only while reset is asserted.

Top module: `adc_frame_deser`

## Requirements
- R1: Asserting `rst_n` low clears `grp_word` and `grp_vld` at once, without waiting for any clock edge.
- R2: In each bit-clock period, the bit captured on the rising edge is one place more significant than the bit captured on the following falling edge. The first rising-edge bit after the frame clock goes high is the word's MSB.
- R3: The resolution code `res_code` sets the word width: 00 gives 8 bits, 01 gives 10, 10 gives 12 and 11 gives 14. The sample is placed in bits [width-1:0].
- R4: Output bits at or above the selected width are zero.
- R5: A frame starts at the bit-clock rising edge where the frame clock is sampled high after having been sampled low at the previous rising edge. A lane word changes only at such a boundary, so a group output holds steady for the whole frame.
- R6: The word of frame k appears on a group output right after the frame-clock rising edge that starts frame k+3.
- R7: `grp_vld` stays low after reset until the first complete frame reaches the output. It then rises together with that word and stays high.
- R8: Group g's two-bit field `grp_sel[2g+1:2g]` picks lane 4g+s, where s is the field value (00 to 11). The field is sampled on the frame-clock rising edge.
- R9: Both groups deliver their selected words in the same frame, each with its own select.
- R10: `grp_clk[g]` is the inverse of the frame clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| dco | input | 1 | Bit clock; lanes are sampled on both edges |
| fco | input | 1 | Frame clock; a low-to-high change marks a sample boundary |
| ser_in | input | 8 | One serial bit stream per lane; lane l on bit l |
| res_code | input | 2 | Resolution code (00=8, 01=10, 10=12, 11=14 bits) |
| grp_sel | input | 4 | Two-bit lane select per group; group g in bits [2g+1:2g] |
| grp_word | output | 28 | Selected word per group; group g in bits [14g+13:14g] |
| grp_vld | output | 2 | Word-valid flag per group |
| grp_clk | output | 2 | Forwarded clock per group (inverted frame clock) |

## Verification
Some properties are checked by assertions on every cycle. These are: unused upper bits stay zero, a lane word holds between frame boundaries, valid rises only at a frame start and never drops, and an output without valid is all zeros. The bench drives whole frames at all four resolutions, with random data and with walking-one data. Only these scenarios can show that the bit order of the rising and falling chains is correct, that the latency is exactly three frames, and that each group's select is sampled on the frame edge. A reset in the middle of a run shows that clearing is asynchronous.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

  typedef enum logic [1:0] {
    RES_8B  = 2'b00,
    RES_10B = 2'b01,
    RES_12B = 2'b10,
    RES_14B = 2'b11
  } res_e;

  // Bit pairs (one rising, one falling) per frame for a resolution code.
  function automatic int unsigned pairs_for(input logic [1:0] code);
    return 32'd4 + 32'(code);
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign srst_n = chain_q[DEPTH-1];

endmodule

// File: rtl/adc_frame_track.sv
module adc_frame_track (
  input  logic dco,
  input  logic rst_n,
  input  logic fco,
  output logic word_upd,
  output logic word_vld
);

  logic fco_prev_q;
  logic seen_q, seen_nxt;
  logic vld_q, vld_nxt;
  logic start;

  // fco is source-synchronous with dco and stable around the rising edge.
  assign start = fco & ~fco_prev_q;

  always_comb begin
    seen_nxt = seen_q;
    vld_nxt  = vld_q;
    if (start) begin
      seen_nxt = 1'b1;
      if (seen_q) begin
        vld_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge dco or negedge rst_n) begin
    if (!rst_n) begin
      fco_prev_q <= 1'b0;
      seen_q     <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      fco_prev_q <= fco;
      seen_q     <= seen_nxt;
      vld_q      <= vld_nxt;
    end
  end

  assign word_upd = start & seen_q;
  assign word_vld = vld_q;

  AST_VLD_ON_START: assert property (@(posedge dco) disable iff (!rst_n)
    $rose(vld_q) |-> $past(start)); // R7

  AST_VLD_STICKY_DCO: assert property (@(posedge dco) disable iff (!rst_n)
    vld_q |=> vld_q); // R7

endmodule

// File: rtl/adc_lane_capture.sv
module adc_lane_capture #(
  parameter int STAGES   = 7,
  parameter int MAX_BITS = 14
) (
  input  logic                dco,
  input  logic                rst_n,
  input  logic                ser,
  input  logic                word_upd,
  input  logic [1:0]          res_code,
  output logic [MAX_BITS-1:0] word
);

  logic [STAGES-1:0]   rise_q, rise_nxt;
  logic [STAGES-1:0]   fall_q, fall_nxt;
  logic [MAX_BITS-1:0] word_q, word_nxt;
  logic [MAX_BITS-1:0] merged;
  int unsigned         pairs;

  assign pairs = adc_deser_pkg::pairs_for(res_code);

  always_comb begin
    rise_nxt = {rise_q[STAGES-2:0], ser};
    fall_nxt = {fall_q[STAGES-2:0], ser};
  end

  // Index 0 holds the newest bit: rise[k] is bit 2k+1, fall[k] is bit 2k.
  always_comb begin
    merged = '0;
    for (int unsigned k = 0; k < STAGES; k++) begin
      if (k < pairs) begin
        merged[2*k+1] = rise_q[k];
        merged[2*k]   = fall_q[k];
      end
    end
  end

  always_comb begin
    word_nxt = word_q;
    if (word_upd) begin
      word_nxt = merged;
    end
  end

  always_ff @(posedge dco or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      word_q <= '0;
    end else begin
      rise_q <= rise_nxt;
      word_q <= word_nxt;
    end
  end

  always_ff @(negedge dco or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else begin
      fall_q <= fall_nxt;
    end
  end

  assign word = word_q;

  AST_UPPER_ZERO: assert property (@(posedge dco) disable iff (!rst_n)
    (word_q >> (2 * pairs)) == '0); // R4

  AST_WORD_HOLD: assert property (@(posedge dco) disable iff (!rst_n)
    !word_upd |=> $stable(word_q)); // R5

endmodule

// File: rtl/adc_group_select.sv
module adc_group_select #(
  parameter int LANES = 4,
  parameter int W     = 14,
  parameter int SEL_W = 2
) (
  input  logic             fco,
  input  logic             rst_n,
  input  logic [LANES*W-1:0] lane_words,
  input  logic             src_vld,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     out_word,
  output logic             out_vld
);

  logic [LANES-1:0][W-1:0] hand_q, hand_nxt;
  logic                    hand_vld_q;
  logic [W-1:0]            out_q, out_nxt;
  logic                    out_vld_q;

  always_comb begin
    hand_nxt = lane_words;
    out_nxt  = hand_q[sel];
  end

  always_ff @(posedge fco or negedge rst_n) begin
    if (!rst_n) begin
      hand_q     <= '0;
      hand_vld_q <= 1'b0;
      out_q      <= '0;
      out_vld_q  <= 1'b0;
    end else begin
      hand_q     <= hand_nxt;
      hand_vld_q <= src_vld;
      out_q      <= out_nxt;
      out_vld_q  <= hand_vld_q;
    end
  end

  assign out_word = out_q;
  assign out_vld  = out_vld_q;

  AST_IDLE_ZERO: assert property (@(posedge fco) disable iff (!rst_n)
    !out_vld_q |-> (out_q == '0)); // R7

  AST_VLD_ORDER: assert property (@(posedge fco) disable iff (!rst_n)
    out_vld_q |-> hand_vld_q); // R7

  AST_VLD_STICKY: assert property (@(posedge fco) disable iff (!rst_n)
    out_vld_q |=> out_vld_q); // R7

endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser #(
  parameter int GROUPS        = 2,
  parameter int LANES_PER_GRP = 4,
  parameter int MAX_BITS      = 14
) (
  input  logic                                      rst_n,
  input  logic                                      dco,
  input  logic                                      fco,
  input  logic [GROUPS*LANES_PER_GRP-1:0]           ser_in,
  input  logic [1:0]                                res_code,
  input  logic [GROUPS*$clog2(LANES_PER_GRP)-1:0]   grp_sel,
  output logic [GROUPS*MAX_BITS-1:0]                grp_word,
  output logic [GROUPS-1:0]                         grp_vld,
  output logic [GROUPS-1:0]                         grp_clk
);

  localparam int LANES  = GROUPS * LANES_PER_GRP;
  localparam int STAGES = MAX_BITS / 2;
  localparam int SEL_W  = $clog2(LANES_PER_GRP);
  localparam int GRP_BUS = LANES_PER_GRP * MAX_BITS;

  logic                      dco_rst_n;
  logic                      fco_rst_n;
  logic                      word_upd;
  logic                      word_vld;
  logic [LANES*MAX_BITS-1:0] lane_bus;

  adc_rst_sync #(.DEPTH(2)) u_rst_dco (
    .clk    (dco),
    .arst_n (rst_n),
    .srst_n (dco_rst_n)
  );

  adc_rst_sync #(.DEPTH(2)) u_rst_fco (
    .clk    (fco),
    .arst_n (rst_n),
    .srst_n (fco_rst_n)
  );

  adc_frame_track u_track (
    .dco      (dco),
    .rst_n    (dco_rst_n),
    .fco      (fco),
    .word_upd (word_upd),
    .word_vld (word_vld)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adc_lane_capture #(
      .STAGES   (STAGES),
      .MAX_BITS (MAX_BITS)
    ) u_cap (
      .dco      (dco),
      .rst_n    (dco_rst_n),
      .ser      (ser_in[l]),
      .word_upd (word_upd),
      .res_code (res_code),
      .word     (lane_bus[l*MAX_BITS +: MAX_BITS])
    );
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    adc_group_select #(
      .LANES (LANES_PER_GRP),
      .W     (MAX_BITS),
      .SEL_W (SEL_W)
    ) u_sel (
      .fco        (fco),
      .rst_n      (fco_rst_n),
      .lane_words (lane_bus[g*GRP_BUS +: GRP_BUS]),
      .src_vld    (word_vld),
      .sel        (grp_sel[g*SEL_W +: SEL_W]),
      .out_word   (grp_word[g*MAX_BITS +: MAX_BITS]),
      .out_vld    (grp_vld[g])
    );
    assign grp_clk[g] = ~fco;
  end

endmodule

// File: tb/tb_adc_frame_deser.sv
`timescale 1ns/1ps
module tb_adc_frame_deser;

  localparam int G   = 2;
  localparam int LPG = 4;
  localparam int W   = 14;
  localparam int NL  = G * LPG;

  logic          rst_n;
  logic          dco;
  logic          fco;
  logic [NL-1:0] ser;
  logic [1:0]    res;
  logic [3:0]    sel;
  logic [G*W-1:0] grp_word;
  logic [G-1:0]  grp_vld;
  logic [G-1:0]  grp_clk;

  int checks;
  int errors;
  bit done;
  logic [NL*W-1:0] hist[$];

  adc_frame_deser dut (
    .rst_n    (rst_n),
    .dco      (dco),
    .fco      (fco),
    .ser_in   (ser),
    .res_code (res),
    .grp_sel  (sel),
    .grp_word (grp_word),
    .grp_vld  (grp_vld),
    .grp_clk  (grp_clk)
  );

  initial dco = 1'b0;
  always #5 dco = ~dco;

  function automatic logic [1:0] sel_for(input int idx, input int g);
    if (g == 0) return 2'(idx % 4);
    return 2'((idx * 3 + 1) % 4);
  endfunction

  function automatic logic [3:0] sel_bus(input int idx);
    return {sel_for(idx, 1), sel_for(idx, 0)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_frame(input logic [NL*W-1:0] fw, input int idx);
    int p;
    logic [W-1:0] snap [G];
    logic [NL*W-1:0] hf;
    p = 4 + int'(res);
    for (int j = 0; j < p; j++) begin
      #1 fco = (j < (p + 1) / 2);
      #1.5;
      for (int l = 0; l < NL; l++) ser[l] = fw[l*W + (2*p - 1 - 2*j)];
      if (j == 0) begin
        #0.5;
        for (int g = 0; g < G; g++) begin
          int s;
          logic [W-1:0] expw;
          logic expv;
          s = int'(sel_for(idx, g));
          expv = (idx >= 3);
          expw = '0;
          if (idx >= 3) begin
            hf = hist[idx-3];
            expw = hf[(g*LPG + s)*W +: W];
          end
          chk("R7 valid", 32'(grp_vld[g]), 32'(expv));
          chk("R2 R3 R6 R8 R9 word", 32'(grp_word[g*W +: W]), 32'(expw));
          if (expv) chk("R4 upper bits", 32'(grp_word[g*W +: W]) >> (2*p), 32'd0);
          snap[g] = grp_word[g*W +: W];
        end
        chk("R10 clock while frame clock high", 32'(grp_clk), 32'd0);
        #1 sel = sel_bus(idx + 1);
      end
      @(posedge dco);
      if (j == p - 1) begin
        #1;
        chk("R10 clock while frame clock low", 32'(grp_clk), 32'd3);
        for (int g = 0; g < G; g++)
          chk("R5 word held within frame", 32'(grp_word[g*W +: W]), 32'(snap[g]));
        #1.5;
      end else begin
        #2.5;
      end
      for (int l = 0; l < NL; l++) ser[l] = fw[l*W + (2*p - 2 - 2*j)];
      @(negedge dco);
    end
  endtask

  task automatic run_seq(input int code, input int kind, input int nfr);
    int n;
    hist.delete();
    rst_n = 1'b0;
    fco   = 1'b0;
    ser   = '0;
    res   = 2'(code);
    sel   = sel_bus(0);
    repeat (2) @(negedge dco);
    chk("R1 valid in reset", 32'(grp_vld), 32'd0);
    chk("R1 word in reset", 32'(grp_word), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge dco);
    n = 2 * (4 + code);
    for (int idx = 0; idx < nfr; idx++) begin
      logic [NL*W-1:0] fw;
      fw = '0;
      for (int l = 0; l < NL; l++) begin
        logic [31:0] v;
        if (kind == 0) v = $urandom & ((32'd1 << n) - 1);
        else           v = 32'd1 << ((idx * NL + l) % n);
        fw[l*W +: W] = v[W-1:0];
      end
      hist.push_back(fw);
      drive_frame(fw, idx);
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    fco    = 1'b0;
    ser    = '0;
    res    = 2'b11;
    sel    = '0;
    @(negedge dco);
    run_seq(3, 1, 8);
    run_seq(0, 1, 8);
    run_seq(0, 0, 8);
    run_seq(1, 0, 8);
    run_seq(2, 0, 8);
    run_seq(3, 0, 10);
    @(negedge dco);
    chk("R7 valid stays high after frames stop", 32'(grp_vld), 32'd3);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 asynchronous clear of valid", 32'(grp_vld), 32'd0);
    chk("R1 asynchronous clear of word", 32'(grp_word), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule